// File: doc/BRIEF.md
# Two-Wire Register Slave Interface

This block is the serial front end of a small sensing device. It sits on a two-wire bus as a slave and watches SCL and SDA through its own synchronizers. It finds START, repeated START and STOP conditions on the system clock and moves bytes in and out with an acknowledge after each one. The slave address is a fixed four-bit prefix followed by three strap pins. The straps are sampled at every START.

A write transfer carries a pointer byte first and then up to two data bytes, most significant byte first. The pointer stays in place after the transfer ends, so later reads return the register it selects without sending it again. The block holds the configuration word and the two limit words, and it takes the temperature result as an input. A write to the one-shot slot produces a trigger pulse. A read transfer raises a pulse that tells the alert logic a read took place.

The block also recognises a high-speed master code, which it leaves unacknowledged and flags until the next STOP. A bus-stuck timer returns the interface to idle if a line stays low too long inside a transfer.

Top module: `twi_reg_slave`

## Requirements
- R1: The slave acknowledges only the address {1001, addr_pins[2:0]} (7 bits, then a direction bit, 1 = read). The pins are sampled at each START. For any other address SDA stays released during the ninth clock.
- R2: In a write transfer the byte after the address is the pointer, and its low 3 bits pick the register. A read returns the register picked by the last pointer written, and a pointer-only write (no data) is legal.
- R3: In a write, the first data byte goes into the upper byte of the register and the second into the lower byte, and the slave acknowledges each byte. The slave never starts driving SDA low while SCL is high.
- R4: A write that ends with STOP after the first data byte changes only the upper byte, and the lower bits keep their old value.
- R5: A read sends the upper byte and then the lower byte, MSB first. Pointer 0 returns {temp_in, 4'b0000}, 2 returns {tlow_lim, 4'b0}, 3 returns {thigh_lim, 4'b0}, and 4 (one-shot) returns 16'h0000.
- R6: The configuration word (pointer 1) holds SD at bit 8, TM at bit 9, POL at bit 10, FQ at bits 12:11 and OS at bit 13. Bits 15:14 and 7:0 read as zero. Reset values are configuration 16'h0000, low limit 16'h4B00 and high limit 16'h5000.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START or STOP.
- R8: A write to pointer 0 (temperature, read only) is acknowledged and leaves every register unchanged.
- R9: A first byte matching 00001xxx is not acknowledged and sets hs_mode. hs_mode stays set across a repeated START and clears at STOP.
- R10: If SCL or SDA stays low without any edge for TOUT_CYC clock cycles between START and STOP, the slave releases SDA, clears hs_mode and waits for a new START.
- R11: rd_stb is a one-cycle pulse for each acknowledged read address and does not fire for writes or for unmatched addresses.
- R12: After reset, sda_oe and hs_mode are 0 and the registers hold their reset values.
- R13: A data byte written to pointer 4 gives a one-cycle oneshot_stb pulse and changes no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| addr_pins | input | 3 | Address strap pins, low three address bits |
| temp_in | input | 12 | Latest temperature result, two's complement |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| hs_mode | output | 1 | High-speed master code seen, held until STOP |
| rd_stb | output | 1 | Pulse: a read transfer was addressed to this slave |
| wr_stb | output | 1 | Pulse: a byte was written to a writable register |
| wr_sel | output | 3 | Register index of the last write pulse |
| oneshot_stb | output | 1 | Pulse: a one-shot conversion was requested |
| cfg_shutdown | output | 1 | Configuration SD bit |
| cfg_intr_mode | output | 1 | Configuration TM bit |
| cfg_pol_high | output | 1 | Configuration POL bit |
| cfg_fault_q | output | 2 | Configuration FQ field |
| cfg_one_shot | output | 1 | Configuration OS bit |
| tlow_lim | output | 12 | Low temperature limit |
| thigh_lim | output | 12 | High temperature limit |

## Verification
The bus-stuck timer can expire in the same cycle in which the slave is pulling SDA low for an acknowledge. That makes the timeout release and the acknowledge drive compete for one flop. The bench provokes this by stopping SCL low in the middle of the ninth clock of an address byte, so the slave's own acknowledge holds SDA low. It then judges the result by checking that SDA is free after the window, that no register changed, and that the next transfer reads back the expected data. A second case stalls the bus right after a high-speed master code and checks that the timeout clears hs_mode.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } twi_state_e;

  typedef enum logic [2:0] {
    BK_ADDR, BK_PTR, BK_HI, BK_LO, BK_XTRA
  } twi_kind_e;

  localparam logic [2:0] REG_TEMP    = 3'd0;
  localparam logic [2:0] REG_CFG     = 3'd1;
  localparam logic [2:0] REG_TLOW    = 3'd2;
  localparam logic [2:0] REG_THIGH   = 3'd3;
  localparam logic [2:0] REG_ONESHOT = 3'd4;

  localparam logic [3:0] ADDR_PREFIX = 4'b1001;
  localparam logic [4:0] HS_PREFIX   = 5'b00001;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/twi_stuck_timer.sv
module twi_stuck_timer #(
  parameter int TOUT_CYC = 1100000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic scl,
  input  logic sda,
  input  logic activity,
  output logic expire
);
  localparam int W = $clog2(TOUT_CYC + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active || activity || (scl && sda)) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else if (cnt == W'(TOUT_CYC - 1)) begin
      cnt    <= '0;
      expire <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      expire <= 1'b0;
    end
  end

  // R10: expiry only follows a window spent inside a transfer
  p_expire_active_r10: assert property (@(posedge clk) disable iff (rst)
    expire |-> $past(active));
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
  import twi_pkg::*;
#(
  parameter int          TW        = 12,
  parameter logic [11:0] TLOW_RST  = 12'h4B0,
  parameter logic [11:0] THIGH_RST = 12'h500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic          wr_hi,
  input  logic [7:0]    wr_byte,
  input  logic [2:0]    rd_sel,
  input  logic [TW-1:0] temp_in,
  output logic [15:0]   rd_word,
  output logic [5:0]    cfg,
  output logic [TW-1:0] tlow,
  output logic [TW-1:0] thigh,
  output logic          wr_stb,
  output logic [2:0]    wr_sel_o,
  output logic          oneshot_stb
);
  localparam int PAD = 16 - TW;
  localparam int LOW = TW - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg         <= '0;
      tlow        <= TW'(TLOW_RST);
      thigh       <= TW'(THIGH_RST);
      wr_stb      <= 1'b0;
      wr_sel_o    <= '0;
      oneshot_stb <= 1'b0;
    end else begin
      wr_stb      <= 1'b0;
      oneshot_stb <= 1'b0;
      if (wr_en) begin
        if (wr_sel != REG_TEMP && wr_sel <= REG_ONESHOT) begin
          wr_stb   <= 1'b1;
          wr_sel_o <= wr_sel;
        end
        case (wr_sel)
          REG_CFG:     if (wr_hi) cfg <= wr_byte[5:0];
          REG_TLOW:    if (wr_hi) tlow[TW-1 -: 8] <= wr_byte;
                       else       tlow[LOW-1:0]   <= wr_byte[7 -: LOW];
          REG_THIGH:   if (wr_hi) thigh[TW-1 -: 8] <= wr_byte;
                       else       thigh[LOW-1:0]   <= wr_byte[7 -: LOW];
          REG_ONESHOT: if (wr_hi) oneshot_stb <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_sel)
      REG_TEMP:  rd_word = {temp_in, {PAD{1'b0}}};
      REG_CFG:   rd_word = {2'b00, cfg, 8'h00};
      REG_TLOW:  rd_word = {tlow, {PAD{1'b0}}};
      REG_THIGH: rd_word = {thigh, {PAD{1'b0}}};
      default:   rd_word = 16'h0000;
    endcase
  end

  // R8: a write aimed at the temperature slot leaves all storage untouched
  p_temp_ro_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == REG_TEMP) |=>
      (cfg == $past(cfg) && tlow == $past(tlow) && thigh == $past(thigh)));

  // R13: the one-shot trigger leaves the limits alone
  p_oneshot_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    oneshot_stb |-> (tlow == $past(tlow) && thigh == $past(thigh)));
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_pkg::*;
#(
  parameter int TOUT_CYC    = 1100000,
  parameter int SYNC_STAGES = 2,
  parameter int TW          = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [2:0]    addr_pins,
  input  logic [TW-1:0] temp_in,
  output logic          sda_oe,
  output logic          hs_mode,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [2:0]    wr_sel,
  output logic          oneshot_stb,
  output logic          cfg_shutdown,
  output logic          cfg_intr_mode,
  output logic          cfg_pol_high,
  output logic [1:0]    cfg_fault_q,
  output logic          cfg_one_shot,
  output logic [TW-1:0] tlow_lim,
  output logic [TW-1:0] thigh_lim
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, lvl, rise, fall;
  assign raw = {sda_in, scl_in};

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_sync
      twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(raw[g]),
        .lvl(lvl[g]), .rise(rise[g]), .fall(fall[g]));
    end
  endgenerate

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  assign scl_s     = lvl[0];
  assign sda_s     = lvl[1];
  assign scl_rise  = rise[0];
  assign scl_fall  = fall[0];
  assign start_det = fall[1] & scl_s;
  assign stop_det  = rise[1] & scl_s;

  twi_state_e  state;
  twi_kind_e   kind;
  logic [2:0]  bitcnt, ptr, pins_l;
  logic [7:0]  sh, tx, nxt_byte;
  logic [15:0] rd_latch, rd_word;
  logic        rx_full, rw, byte_lo, mack, busy, tmo;
  logic        bk_wr, bk_hi;
  logic [7:0]  bk_byte;
  logic [5:0]  cfg;

  twi_stuck_timer #(.TOUT_CYC(TOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .active(busy), .scl(scl_s), .sda(sda_s),
    .activity(|rise | |fall), .expire(tmo));

  twi_reg_bank #(.TW(TW)) u_bank (
    .clk(clk), .rst(rst), .wr_en(bk_wr), .wr_sel(ptr), .wr_hi(bk_hi),
    .wr_byte(bk_byte), .rd_sel(ptr), .temp_in(temp_in), .rd_word(rd_word),
    .cfg(cfg), .tlow(tlow_lim), .thigh(thigh_lim), .wr_stb(wr_stb),
    .wr_sel_o(wr_sel), .oneshot_stb(oneshot_stb));

  assign cfg_shutdown  = cfg[0];
  assign cfg_intr_mode = cfg[1];
  assign cfg_pol_high  = cfg[2];
  assign cfg_fault_q   = cfg[4:3];
  assign cfg_one_shot  = cfg[5];

  assign nxt_byte = byte_lo ? rd_latch[7:0] : rd_latch[15:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      kind     <= BK_ADDR;
      bitcnt   <= '0;
      ptr      <= '0;
      pins_l   <= '0;
      sh       <= '0;
      tx       <= '0;
      rd_latch <= '0;
      rx_full  <= 1'b0;
      rw       <= 1'b0;
      byte_lo  <= 1'b0;
      mack     <= 1'b0;
      busy     <= 1'b0;
      sda_oe   <= 1'b0;
      hs_mode  <= 1'b0;
      rd_stb   <= 1'b0;
      bk_wr    <= 1'b0;
      bk_hi    <= 1'b0;
      bk_byte  <= '0;
    end else begin
      rd_stb <= 1'b0;
      bk_wr  <= 1'b0;
      if (tmo || stop_det) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        busy    <= 1'b0;
        hs_mode <= 1'b0;
      end else if (start_det) begin
        state   <= ST_RX;
        kind    <= BK_ADDR;
        bitcnt  <= '0;
        rx_full <= 1'b0;
        sda_oe  <= 1'b0;
        busy    <= 1'b1;
        pins_l  <= addr_pins;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) rx_full <= 1'b1;
            end else if (scl_fall && rx_full) begin
              rx_full <= 1'b0;
              case (kind)
                BK_ADDR: begin
                  if (sh[7:3] == HS_PREFIX) begin
                    hs_mode <= 1'b1;
                    state   <= ST_WAIT;
                  end else if (sh[7:1] == {ADDR_PREFIX, pins_l}) begin
                    sda_oe <= 1'b1;
                    rw     <= sh[0];
                    state  <= ST_RX_ACK;
                    if (sh[0]) begin
                      rd_stb   <= 1'b1;
                      rd_latch <= rd_word;
                      byte_lo  <= 1'b0;
                    end
                  end else begin
                    state <= ST_WAIT;
                  end
                end
                BK_PTR: begin
                  ptr    <= sh[2:0];
                  kind   <= BK_HI;
                  sda_oe <= 1'b1;
                  state  <= ST_RX_ACK;
                end
                BK_HI, BK_LO: begin
                  bk_wr   <= 1'b1;
                  bk_hi   <= (kind == BK_HI);
                  bk_byte <= sh;
                  kind    <= (kind == BK_HI) ? BK_LO : BK_XTRA;
                  sda_oe  <= 1'b1;
                  state   <= ST_RX_ACK;
                end
                default: begin
                  sda_oe <= 1'b1;
                  state  <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw && kind == BK_ADDR) begin
                sda_oe  <= ~nxt_byte[7];
                tx      <= {nxt_byte[6:0], 1'b0};
                byte_lo <= ~byte_lo;
                state   <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
                if (kind == BK_ADDR) kind <= BK_PTR;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= ST_TX_ACK;
              end else begin
                sda_oe <= ~tx[7];
                tx     <= {tx[6:0], 1'b0};
                bitcnt <= bitcnt + 3'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                sda_oe  <= ~nxt_byte[7];
                tx      <= {nxt_byte[6:0], 1'b0};
                byte_lo <= ~byte_lo;
                state   <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: STOP always returns SDA and the high-speed flag to rest
  p_stop_rest_r9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && !hs_mode));

  // R10: timer expiry frees the data line
  p_tmo_release_r10: assert property (@(posedge clk) disable iff (rst)
    tmo |=> (!sda_oe && !hs_mode));

  // R3: a new pull-down only begins while SCL is low
  p_drive_on_low_r3: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && !$past(sda_oe)) |-> !scl_s);

  // R11: the read pulse lasts one cycle
  p_rd_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb);

  // R11: read pulse and bank write never coincide
  p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_stb, bk_wr}));
endmodule

// File: tb/twi_reg_slave_test.sv
module twi_reg_slave_test;
  localparam int TOUT = 400;
  localparam int Q    = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  addr_pins = 3'b101;
  logic [11:0] temp_in = 12'h000;
  logic        sda_oe, hs_mode, rd_stb, wr_stb, oneshot_stb;
  logic [2:0]  wr_sel;
  logic        cfg_shutdown, cfg_intr_mode, cfg_pol_high, cfg_one_shot;
  logic [1:0]  cfg_fault_q;
  logic [11:0] tlow_lim, thigh_lim;
  logic        sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  twi_reg_slave #(.TOUT_CYC(TOUT)) uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
    .addr_pins(addr_pins), .temp_in(temp_in), .sda_oe(sda_oe),
    .hs_mode(hs_mode), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .oneshot_stb(oneshot_stb), .cfg_shutdown(cfg_shutdown),
    .cfg_intr_mode(cfg_intr_mode), .cfg_pol_high(cfg_pol_high),
    .cfg_fault_q(cfg_fault_q), .cfg_one_shot(cfg_one_shot),
    .tlow_lim(tlow_lim), .thigh_lim(thigh_lim));

  int errs = 0, checks = 0, rd_cnt = 0, os_cnt = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst && rd_stb) rd_cnt++;
    if (!rst && oneshot_stb) os_cnt++;
  end

  // scoreboard: expected read bytes queued by the driver
  logic [7:0] exp_q[$];
  string      req_q[$];
  bit         cap = 0;
  logic [7:0] mbyte = 0;
  int         mbits = 0;

  always @(posedge scl_m) begin
    if (cap) begin
      mbyte = {mbyte[6:0], sda_bus};
      mbits++;
      if (mbits == 8) begin
        mbits = 0;
        if (exp_q.size() == 0) chk("scoreboard", 1, 0);
        else chk(req_q.pop_front(), mbyte, exp_q.pop_front());
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1; scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic m_rstart();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic m_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq();
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) m_wbit(b[i]);
    sda_m = 1; wq(); scl_m = 1; wq(); ack = ~sda_bus; wq(); scl_m = 0; wq();
  endtask

  task automatic m_rbyte(input logic give_ack, input logic [7:0] e,
                         input string req);
    exp_q.push_back(e); req_q.push_back(req);
    sda_m = 1; cap = 1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1; wq(); wq(); scl_m = 0;
    end
    cap = 0;
    wq();
    m_wbit(~give_ack);
    sda_m = 1;
  endtask

  function automatic logic [7:0] adr(input logic [2:0] p, input logic r);
    return {4'b1001, p, r};
  endfunction

  task automatic do_write(input logic [2:0] p, input logic [7:0] ptr,
                          input int n, input logic [7:0] d0,
                          input logic [7:0] d1, input string req);
    logic a;
    m_start();
    m_wbyte(adr(p, 0), a); chk({req, " addr ack"}, a, 1);
    m_wbyte(ptr, a);       chk({req, " ptr ack"}, a, 1);
    if (n > 0) begin m_wbyte(d0, a); chk({req, " R3 hi ack"}, a, 1); end
    if (n > 1) begin m_wbyte(d1, a); chk({req, " R3 lo ack"}, a, 1); end
    m_stop();
  endtask

  task automatic do_read(input logic [2:0] p, input logic [7:0] e0,
                         input logic [7:0] e1, input string req);
    logic a;
    m_start();
    m_wbyte(adr(p, 1), a); chk({req, " read addr ack"}, a, 1);
    m_rbyte(1, e0, {req, " hi byte"});
    m_rbyte(0, e1, {req, " lo byte"});
    m_stop();
  endtask

  initial begin
    logic a;
    int rd_before;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (5) @(negedge clk);
    // R12 / R6 reset state
    chk("R12 sda_oe", sda_oe, 0);
    chk("R12 hs_mode", hs_mode, 0);
    chk("R6 cfg reset", {cfg_one_shot, cfg_fault_q, cfg_pol_high,
                         cfg_intr_mode, cfg_shutdown}, 0);
    chk("R6 tlow reset", tlow_lim, 12'h4B0);
    chk("R6 thigh reset", thigh_lim, 12'h500);

    // R3 full write, R2 pointer persistence, R5 read order
    do_write(3'b101, 8'h02, 2, 8'h12, 8'h34, "R2");
    chk("R3 tlow", tlow_lim, 12'h123);
    rd_before = rd_cnt;
    do_read(3'b101, 8'h12, 8'h30, "R5 tlow");
    chk("R11 one pulse per read", rd_cnt - rd_before, 1);
    chk("R11 no pulse on write", rd_before, 0);

    // R1 address mismatch and strap resampling
    m_start(); m_wbyte(adr(3'b100, 1), a); m_stop();
    chk("R1 wrong addr nack", a, 0);
    chk("R11 no pulse on mismatch", rd_cnt, 1);
    addr_pins = 3'b000;
    do_read(3'b000, 8'h12, 8'h30, "R1 new straps");
    m_start(); m_wbyte(adr(3'b101, 0), a); m_stop();
    chk("R1 old straps nack", a, 0);

    // R4 upper-byte-only write
    do_write(3'b000, 8'h03, 2, 8'h7F, 8'hF0, "R4 setup");
    do_write(3'b000, 8'h03, 1, 8'h66, 8'h00, "R4");
    chk("R4 thigh", thigh_lim, 12'h66F);
    do_read(3'b000, 8'h66, 8'hF0, "R4 readback");

    // R6 configuration layout
    do_write(3'b000, 8'h01, 2, 8'hFF, 8'hFF, "R6");
    chk("R6 all set", {cfg_one_shot, cfg_fault_q, cfg_pol_high,
                       cfg_intr_mode, cfg_shutdown}, 6'h3F);
    do_read(3'b000, 8'h3F, 8'h00, "R6 reserved zero");
    do_write(3'b000, 8'h01, 2, 8'h0A, 8'h00, "R6 fields");
    chk("R6 TM bit9", cfg_intr_mode, 1);
    chk("R6 FQ bits12:11", cfg_fault_q, 1);
    chk("R6 SD bit8", cfg_shutdown, 0);

    // R8 temperature is read only
    temp_in = 12'hE70;
    do_write(3'b000, 8'h00, 2, 8'h55, 8'h55, "R8");
    chk("R8 tlow kept", tlow_lim, 12'h123);
    chk("R8 thigh kept", thigh_lim, 12'h66F);
    do_read(3'b000, 8'hE7, 8'h00, "R8 temp read");

    // R13 one-shot trigger, R5 write-only slot reads zero
    do_write(3'b000, 8'h04, 1, 8'hAA, 8'h00, "R13");
    chk("R13 oneshot pulses", os_cnt, 1);
    chk("R13 tlow kept", tlow_lim, 12'h123);
    do_read(3'b000, 8'h00, 8'h00, "R5 oneshot read");

    // R2 pointer-only write, R7 NACK ends the read
    do_write(3'b000, 8'h02, 0, 8'h00, 8'h00, "R2 ptr only");
    m_start(); m_wbyte(adr(3'b000, 1), a);
    chk("R7 addr ack", a, 1);
    m_rbyte(0, 8'h12, "R7 single byte");
    begin
      int lows = 0;
      for (int i = 0; i < 9; i++) begin
        wq(); scl_m = 1; wq(); if (!sda_bus) lows++; wq(); scl_m = 0; wq();
      end
      chk("R7 released after nack", lows, 0);
    end
    m_stop();

    // R9 high-speed master code
    m_start(); m_wbyte(8'h0B, a);
    chk("R9 code not acked", a, 0);
    chk("R9 hs set", hs_mode, 1);
    m_rstart(); m_wbyte(adr(3'b000, 0), a);
    chk("R9 addr after code", a, 1);
    chk("R9 hs kept over Sr", hs_mode, 1);
    m_wbyte(8'h02, a);
    m_stop();
    chk("R9 hs cleared at stop", hs_mode, 0);

    // R10 timeout while the slave holds its acknowledge
    m_start();
    for (int i = 7; i >= 0; i--) m_wbit(adr(3'b000, 0) >> i);
    sda_m = 1; wq();
    chk("R10 ack driven", sda_oe, 1);
    repeat (TOUT + 40) @(negedge clk);
    chk("R10 released", sda_oe, 0);
    chk("R10 bus high", sda_bus, 1);
    m_stop();
    chk("R10 tlow kept", tlow_lim, 12'h123);
    do_read(3'b000, 8'h12, 8'h30, "R10 recovery");

    // R10 timeout after a master code clears hs_mode
    m_start(); m_wbyte(8'h08, a);
    chk("R10 hs set before stall", hs_mode, 1);
    repeat (TOUT + 40) @(negedge clk);
    chk("R10 hs cleared", hs_mode, 0);
    scl_m = 1; wq(); wq();

    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule